// File: doc/BRIEF.md
# Windowed frame-buffer line address generator

This block turns a rectangular window inside a stored image into a sequence of memory line requests. Each frame sits in external memory as a raster whose rows are padded to a fixed pitch. Several frames are kept back to back in a ring. The block presents one request per window row. Each request carries the first burst address of that row and the number of 16-byte bursts to move. The memory side consumes a request by pulsing an acknowledge.

Software programs the geometry through a simple register-write port. The geometry is the ring start address, the per-frame address step, the index of the last frame in the ring, the row pitch, the window size and origin, and a start point inside the window. A frame-start strobe then begins one pass over the window. The geometry is copied into a working set when a pass is accepted, so writes made during a pass only apply to the next one. After the last row is acknowledged, a one-cycle done pulse is given and the ring advances to the next frame.

Top module: `win_line_gen`

## Requirements
- R1: After the `rst` input, `line_req` and `frame_done` are low and `frame_num` is 0. The control register resets to 0, which holds the block in soft reset.
- R2: The control register is at offset 0, with bit 0 an active-low soft reset and bit 1 an enable. A `frame_start` pulse is accepted only when both bits are 1 and no pass is running. `line_req` rises in the cycle after an accepted strobe. Other strobes have no effect.
- R3: Row addresses are computed modulo 2^22 as base + (top + y) × pitch + left + x, in burst units. The base is the ring start address (offset 2, bits 21:0) plus the current frame offset. The pitch is at offset 5, bits 12:0. Left and top are at offset 7, bits 12:0 and 31:16.
- R4: The first row of a pass is row start-y and begins at start-x. The start point is at offset 8, with x in bits 12:0 and y in bits 31:16. Its length is width − start-x. Every later row begins at x = 0 with the full width. Width and height are at offset 6, bits 12:0 and 31:16.
- R5: A width field of 0 means 0x4000 bursts, and a height field of 0 means 0x10000 rows.
- R6: A request holds its address and length until it is acknowledged. Each acknowledge advances y by exactly one row.
- R7: `frame_done` is high for exactly one cycle, in the cycle after the last window row (y = height − 1) is acknowledged, and `line_req` is low in that cycle.
- R8: At the end of each pass, the frame index and frame offset advance. The index counts up by 1, and the offset grows by the step at offset 3. When the index equals the last-frame value (offset 4, bits 15:0), both the index and the offset return to 0 instead. `frame_num` shows the index.
- R9: Geometry writes made while a pass runs do not change that pass. They take effect at the next accepted frame start.
- R10: While the soft-reset bit is 0, the frame index, the frame offset and the row counter are held at 0, and no request is given.
- R11: Writes to offset 1 and to offsets 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_data | input | 32 | Register write data |
| frame_start | input | 1 | Begin a pass over the window |
| line_ack | input | 1 | Current row request consumed |
| line_req | output | 1 | Row request valid |
| line_addr | output | 22 | First burst address of the row |
| line_len | output | 15 | Row length in bursts |
| frame_done | output | 1 | One-cycle pulse after the last row |
| frame_num | output | 16 | Current ring frame index |

## Verification
The assertions assume that the start point lies inside the window, with start-x below the decoded width and start-y below the decoded height. They also assume that the acknowledge is only meaningful while a request is shown. Under these assumptions the row length is never zero and every pass ends. The stimulus keeps every programmed start point inside its window, including for the zero-coded maximum sizes. It drives the acknowledge in held-off, always-on and random patterns. Soft reset is dropped only at chosen points, and the hold property excuses the cycle in which it happens.

// File: rtl/wlg_pkg.sv
package wlg_pkg;
  typedef enum logic [3:0] {
    OFS_CTRL  = 4'd0,
    OFS_STAT  = 4'd1,
    OFS_BASE  = 4'd2,
    OFS_STEP  = 4'd3,
    OFS_LAST  = 4'd4,
    OFS_PITCH = 4'd5,
    OFS_SIZE  = 4'd6,
    OFS_ORG   = 4'd7,
    OFS_POS   = 4'd8
  } reg_ofs_e;
  localparam int HALF = 16;
endpackage

// File: rtl/wlg_regs.sv
module wlg_regs #(
  parameter int ADDR_W  = 22,
  parameter int FRM_W   = 16,
  parameter int PITCH_W = 13,
  parameter int WID_W   = 13,
  parameter int HGT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [3:0]         addr,
  input  logic [31:0]        data,
  input  logic               take,
  output logic               run,
  output logic               en,
  output logic [ADDR_W-1:0]  act_start,
  output logic [ADDR_W-1:0]  act_step,
  output logic [FRM_W-1:0]   act_last,
  output logic [PITCH_W-1:0] act_pitch,
  output logic [WID_W-1:0]   act_wid,
  output logic [HGT_W-1:0]   act_hgt,
  output logic [WID_W-1:0]   act_left,
  output logic [HGT_W-1:0]   act_top,
  output logic [WID_W-1:0]   act_sx,
  output logic [HGT_W-1:0]   act_sy
);
  import wlg_pkg::*;

  logic [ADDR_W-1:0]  p_start, p_step;
  logic [FRM_W-1:0]   p_last;
  logic [PITCH_W-1:0] p_pitch;
  logic [WID_W-1:0]   p_wid, p_left, p_sx;
  logic [HGT_W-1:0]   p_hgt, p_top, p_sy;

  // pending set: written by software at any time
  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; en <= 1'b0;
      p_start <= '0; p_step <= '0; p_last <= '0; p_pitch <= '0;
      p_wid <= '0; p_hgt <= '0; p_left <= '0; p_top <= '0;
      p_sx <= '0; p_sy <= '0;
    end else if (we) begin
      case (reg_ofs_e'(addr))
        OFS_CTRL:  begin run <= data[0]; en <= data[1]; end
        OFS_BASE:  p_start <= data[ADDR_W-1:0];
        OFS_STEP:  p_step  <= data[ADDR_W-1:0];
        OFS_LAST:  p_last  <= data[FRM_W-1:0];
        OFS_PITCH: p_pitch <= data[PITCH_W-1:0];
        OFS_SIZE:  begin p_wid <= data[WID_W-1:0]; p_hgt <= data[HALF +: HGT_W]; end
        OFS_ORG:   begin p_left <= data[WID_W-1:0]; p_top <= data[HALF +: HGT_W]; end
        OFS_POS:   begin p_sx <= data[WID_W-1:0]; p_sy <= data[HALF +: HGT_W]; end
        default:   ;
      endcase
    end
  end

  // working set: copied when a pass is accepted
  always_ff @(posedge clk) begin
    if (rst) begin
      act_start <= '0; act_step <= '0; act_last <= '0; act_pitch <= '0;
      act_wid <= '0; act_hgt <= '0; act_left <= '0; act_top <= '0;
      act_sx <= '0; act_sy <= '0;
    end else if (take) begin
      act_start <= p_start; act_step <= p_step; act_last <= p_last;
      act_pitch <= p_pitch; act_wid <= p_wid; act_hgt <= p_hgt;
      act_left <= p_left; act_top <= p_top; act_sx <= p_sx; act_sy <= p_sy;
    end
  end
endmodule

// File: rtl/wlg_ring.sv
module wlg_ring #(
  parameter int ADDR_W = 22,
  parameter int FRM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              advance,
  input  logic [FRM_W-1:0]  last,
  input  logic [ADDR_W-1:0] step,
  output logic [FRM_W-1:0]  frame_idx,
  output logic [ADDR_W-1:0] frame_off
);
  logic at_last;
  assign at_last = (frame_idx == last);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      frame_idx <= '0;
      frame_off <= '0;
    end else if (advance) begin
      if (at_last) begin
        frame_idx <= '0;
        frame_off <= '0;
      end else begin
        frame_idx <= frame_idx + FRM_W'(1);
        frame_off <= frame_off + step;
      end
    end
  end
endmodule

// File: rtl/wlg_walk.sv
module wlg_walk #(
  parameter int ADDR_W  = 22,
  parameter int PITCH_W = 13,
  parameter int WID_W   = 13,
  parameter int HGT_W   = 16,
  localparam int YW     = HGT_W + 1,
  localparam int LEN_W  = WID_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               en,
  input  logic               start,
  input  logic               ack,
  input  logic [ADDR_W-1:0]  act_start,
  input  logic [ADDR_W-1:0]  frame_off,
  input  logic [PITCH_W-1:0] act_pitch,
  input  logic [WID_W-1:0]   act_wid,
  input  logic [HGT_W-1:0]   act_hgt,
  input  logic [WID_W-1:0]   act_left,
  input  logic [HGT_W-1:0]   act_top,
  input  logic [WID_W-1:0]   act_sx,
  input  logic [HGT_W-1:0]   act_sy,
  output logic               take,
  output logic               pass_end,
  output logic               line_req,
  output logic [ADDR_W-1:0]  line_addr,
  output logic [LEN_W-1:0]   line_len,
  output logic               frame_done
);
  localparam int PROD_W = YW + PITCH_W;

  function automatic logic [LEN_W-1:0] dec_width(input logic [WID_W-1:0] f);
    return (f == '0) ? (LEN_W'(1) << (WID_W + 1)) : LEN_W'(f);
  endfunction

  function automatic logic [YW-1:0] dec_height(input logic [HGT_W-1:0] f);
    return (f == '0) ? (YW'(1) << HGT_W) : YW'(f);
  endfunction

  function automatic logic [ADDR_W-1:0] row_address(
    input logic [ADDR_W-1:0]  base,
    input logic [HGT_W-1:0]   top,
    input logic [YW-1:0]      y,
    input logic [PITCH_W-1:0] pitch,
    input logic [WID_W-1:0]   left,
    input logic [WID_W-1:0]   x);
    logic [YW-1:0]     row;
    logic [PROD_W-1:0] prod;
    row  = YW'(top) + y;
    prod = PROD_W'(row) * PROD_W'(pitch);
    return base + ADDR_W'(prod) + ADDR_W'(left) + ADDR_W'(x);
  endfunction

  logic          busy, done_q;
  logic [YW-1:0] cnt, y_abs;
  logic          last_row;
  logic [WID_W-1:0] xoff;

  assign y_abs    = YW'(act_sy) + cnt;
  assign last_row = (y_abs == dec_height(act_hgt) - YW'(1));
  assign xoff     = (cnt == '0) ? act_sx : '0;
  assign take     = start & en & run & ~busy;
  assign pass_end = busy & ack & last_row;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      busy   <= 1'b0;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= pass_end;
      if (take) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy && ack) begin
        if (last_row) busy <= 1'b0;
        else          cnt  <= cnt + YW'(1);
      end
    end
  end

  assign line_req   = busy;
  assign line_addr  = row_address(act_start + frame_off, act_top, y_abs,
                                  act_pitch, act_left, xoff);
  assign line_len   = dec_width(act_wid) - LEN_W'(xoff);
  assign frame_done = done_q;
endmodule

// File: rtl/win_line_gen.sv
module win_line_gen #(
  parameter int ADDR_W  = 22,
  parameter int FRM_W   = 16,
  parameter int PITCH_W = 13,
  parameter int WID_W   = 13,
  parameter int HGT_W   = 16,
  localparam int LEN_W  = WID_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_data,
  input  logic              frame_start,
  input  logic              line_ack,
  output logic              line_req,
  output logic [ADDR_W-1:0] line_addr,
  output logic [LEN_W-1:0]  line_len,
  output logic              frame_done,
  output logic [FRM_W-1:0]  frame_num
);
  logic               w_run, w_en, w_take, w_pass_end;
  logic [ADDR_W-1:0]  a_start, a_step, f_off;
  logic [FRM_W-1:0]   a_last;
  logic [PITCH_W-1:0] a_pitch;
  logic [WID_W-1:0]   a_wid, a_left, a_sx;
  logic [HGT_W-1:0]   a_hgt, a_top, a_sy;

  wlg_regs #(.ADDR_W(ADDR_W), .FRM_W(FRM_W), .PITCH_W(PITCH_W),
             .WID_W(WID_W), .HGT_W(HGT_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .data(reg_data),
    .take(w_take), .run(w_run), .en(w_en),
    .act_start(a_start), .act_step(a_step), .act_last(a_last),
    .act_pitch(a_pitch), .act_wid(a_wid), .act_hgt(a_hgt),
    .act_left(a_left), .act_top(a_top), .act_sx(a_sx), .act_sy(a_sy));

  wlg_ring #(.ADDR_W(ADDR_W), .FRM_W(FRM_W)) u_ring (
    .clk(clk), .rst(rst), .run(w_run), .advance(w_pass_end),
    .last(a_last), .step(a_step), .frame_idx(frame_num), .frame_off(f_off));

  wlg_walk #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .WID_W(WID_W),
             .HGT_W(HGT_W)) u_walk (
    .clk(clk), .rst(rst), .run(w_run), .en(w_en), .start(frame_start),
    .ack(line_ack), .act_start(a_start), .frame_off(f_off),
    .act_pitch(a_pitch), .act_wid(a_wid), .act_hgt(a_hgt),
    .act_left(a_left), .act_top(a_top), .act_sx(a_sx), .act_sy(a_sy),
    .take(w_take), .pass_end(w_pass_end), .line_req(line_req),
    .line_addr(line_addr), .line_len(line_len), .frame_done(frame_done));
endmodule

// File: rtl/wlg_chk.sv
module wlg_chk #(
  parameter int ADDR_W = 22,
  parameter int FRM_W  = 16,
  parameter int LEN_W  = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              line_req,
  input logic              line_ack,
  input logic [ADDR_W-1:0] line_addr,
  input logic [LEN_W-1:0]  line_len,
  input logic              frame_done,
  input logic [FRM_W-1:0]  frame_num,
  input logic              run,
  input logic              take
);
  p_take_req_r2: assert property (@(posedge clk) disable iff (rst)
    take |=> line_req);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (line_req && !line_ack) |=>
      (!run || (line_req && $stable(line_addr) && $stable(line_len))));

  p_done_r7: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (!line_req && $past(line_req && line_ack)));

  p_len_r5: assert property (@(posedge clk) disable iff (rst)
    line_req |-> (line_len != '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!line_req && !frame_done && frame_num == '0));
endmodule

bind win_line_gen wlg_chk #(.ADDR_W(ADDR_W), .FRM_W(FRM_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .line_req(line_req), .line_ack(line_ack),
  .line_addr(line_addr), .line_len(line_len), .frame_done(frame_done),
  .frame_num(frame_num), .run(w_run), .take(w_take));

// File: tb/win_line_gen_tb.sv
`timescale 1ns/1ps
module win_line_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_data = '0;
  logic        frame_start = 1'b0;
  logic        line_ack = 1'b0;
  logic        line_req;
  logic [21:0] line_addr;
  logic [14:0] line_len;
  logic        frame_done;
  logic [15:0] frame_num;

  int tests = 0, fails = 0;
  int ack_mode = 0;
  int acked = 0;
  bit finished = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  win_line_gen u_dut (.clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_data(reg_data), .frame_start(frame_start), .line_ack(line_ack),
    .line_req(line_req), .line_addr(line_addr), .line_len(line_len),
    .frame_done(frame_done), .frame_num(frame_num));

  // behavioural reference model
  longint p_start, p_step, p_last, p_pitch, p_wid, p_hgt, p_left, p_top, p_sx, p_sy;
  longint a_start, a_step, a_last, a_pitch, a_wid, a_hgt, a_left, a_top, a_sx, a_sy;
  longint m_cnt, m_idx, m_off;
  bit m_run, m_en, m_busy, m_done;
  localparam longint AMOD = 64'd4194304;

  always @(posedge clk) begin
    if (!rst && line_req && line_ack) acked++;
    if (rst) begin
      {p_start, p_step, p_last, p_pitch, p_wid, p_hgt, p_left, p_top, p_sx, p_sy} = '0;
      {a_start, a_step, a_last, a_pitch, a_wid, a_hgt, a_left, a_top, a_sx, a_sy} = '0;
      m_cnt = 0; m_idx = 0; m_off = 0;
      m_run = 0; m_en = 0; m_busy = 0; m_done = 0;
    end else begin
      longint h;
      bit take, fire, lastl;
      h = (a_hgt == 0) ? 65536 : a_hgt;
      take  = frame_start && m_en && m_run && !m_busy;
      fire  = m_busy && line_ack;
      lastl = fire && (a_sy + m_cnt == h - 1);
      if (!m_run) begin
        m_busy = 0; m_cnt = 0; m_idx = 0; m_off = 0; m_done = 0;
      end else begin
        m_done = lastl;
        if (take) begin
          a_start = p_start; a_step = p_step; a_last = p_last; a_pitch = p_pitch;
          a_wid = p_wid; a_hgt = p_hgt; a_left = p_left; a_top = p_top;
          a_sx = p_sx; a_sy = p_sy;
          m_busy = 1; m_cnt = 0;
        end else if (fire) begin
          if (lastl) begin
            m_busy = 0;
            if (m_idx == a_last) begin m_idx = 0; m_off = 0; end
            else begin m_idx = m_idx + 1; m_off = (m_off + a_step) % AMOD; end
          end else m_cnt = m_cnt + 1;
        end
      end
      if (reg_we) begin
        case (reg_addr)
          4'd0: begin m_run = reg_data[0]; m_en = reg_data[1]; end
          4'd2: p_start = reg_data[21:0];
          4'd3: p_step  = reg_data[21:0];
          4'd4: p_last  = reg_data[15:0];
          4'd5: p_pitch = reg_data[12:0];
          4'd6: begin p_wid = reg_data[12:0]; p_hgt = reg_data[31:16]; end
          4'd7: begin p_left = reg_data[12:0]; p_top = reg_data[31:16]; end
          4'd8: begin p_sx = reg_data[12:0]; p_sy = reg_data[31:16]; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint got, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (%s) %s: got %0h expected %0h", req, tag, what, got, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      longint w, x, ea, el;
      chk(line_req == m_busy, "R2", "line_req", line_req, m_busy);
      chk(frame_done == m_done, "R7", "frame_done", frame_done, m_done);
      chk(frame_num == m_idx, "R8", "frame_num", frame_num, m_idx);
      if (m_busy) begin
        w  = (a_wid == 0) ? 16384 : a_wid;
        x  = (m_cnt == 0) ? a_sx : 0;
        ea = (a_start + m_off + (a_top + a_sy + m_cnt) * a_pitch + a_left + x) % AMOD;
        el = w - x;
        chk(line_addr == ea, "R3", "line_addr", line_addr, ea);
        chk(line_len == el, "R4", "line_len", line_len, el);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    reg_we = 0; frame_start = 0;
    line_ack = (ack_mode == 1) || (ack_mode == 2 && ($urandom % 2) == 1);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(); reg_we = 1; reg_addr = a; reg_data = d;
  endtask

  task automatic start_frame();
    step(); frame_start = 1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 70000; i++) begin
      step();
      if (frame_done) break;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int base_cnt;
    repeat (3) step();
    rst = 0;
    step(); step();
    tag = "R1";
    chk(line_req == 0, "R1", "line_req after reset", line_req, 0);
    chk(frame_done == 0, "R1", "frame_done after reset", frame_done, 0);
    chk(frame_num == 0, "R1", "frame_num after reset", frame_num, 0);

    wr(4'd2, 32'h1000); wr(4'd3, 32'h800); wr(4'd4, 32'd2); wr(4'd5, 32'hC0);
    wr(4'd6, {16'd4, 16'd10}); wr(4'd7, {16'd2, 16'd3}); wr(4'd8, {16'd1, 16'd4});
    start_frame(); step(); step();
    chk(line_req == 0, "R1", "soft reset held by control reset value", line_req, 0);
    wr(4'd0, 32'd3);

    tag = "R3"; ack_mode = 1;
    start_frame(); step();
    chk(line_addr == 22'd4679, "R3", "first row address", line_addr, 4679);
    chk(line_len == 15'd6, "R4", "first row length", line_len, 6);
    wait_done();

    tag = "R8"; ack_mode = 2;
    start_frame(); wait_done();
    start_frame(); wait_done();
    step();
    chk(frame_num == 0, "R8", "index wrap after last frame", frame_num, 0);
    tag = "R6";
    start_frame(); wait_done();

    tag = "R2";
    wr(4'd0, 32'd1);
    start_frame(); step(); step(); step();
    chk(line_req == 0, "R2", "strobe ignored when disabled", line_req, 0);
    wr(4'd0, 32'd3);
    start_frame(); step(); frame_start = 1; step();
    wait_done();

    tag = "R9"; ack_mode = 0;
    start_frame(); step();
    wr(4'd6, {16'd2, 16'd20}); wr(4'd8, {16'd0, 16'd0});
    ack_mode = 2; wait_done();
    start_frame(); wait_done();

    tag = "R11";
    wr(4'd1, 32'hFFFF_FFFF); wr(4'd9, 32'h0012_3456); wr(4'd15, 32'hFFFF_FFFF);
    start_frame(); wait_done();

    tag = "R5"; ack_mode = 0;
    wr(4'd6, 32'h0); wr(4'd8, {16'd65533, 16'd5}); wr(4'd7, 32'h0);
    start_frame(); step();
    chk(line_len == 15'd16379, "R5", "zero width first row length", line_len, 16379);
    base_cnt = acked;
    ack_mode = 1; wait_done();
    chk((acked - base_cnt) == 3, "R5", "rows in zero-height pass", acked - base_cnt, 3);

    tag = "R10"; ack_mode = 0;
    wr(4'd6, {16'd5, 16'd8}); wr(4'd8, 32'h0);
    start_frame(); step(); step();
    wr(4'd0, 32'd2); step(); step();
    chk(frame_num == 0, "R10", "index held in soft reset", frame_num, 0);
    chk(line_req == 0, "R10", "no request in soft reset", line_req, 0);
    start_frame(); step(); step();
    chk(line_req == 0, "R10", "strobe ignored in soft reset", line_req, 0);
    wr(4'd0, 32'd3); ack_mode = 2;
    start_frame(); wait_done();
    repeat (3) step();
    summary();
  end
endmodule